// File: doc/BRIEF.md
# Pixel Matrix Row Sequencer

This block steps through the rows of a pixel matrix one at a time. Each row has two drive lines: a gate line that switches the row on for readout, and a clear line that empties the collected charge. For each row the sequencer runs the same fixed order. It switches the gate on and waits a settle time, then issues a first sample strobe (signal plus pedestal). It then pulses the row's clear line and waits a post-clear settle time. Finally it issues a second sample strobe (pedestal only) and moves to the next row.

A readout system raises `run` for the length of a particle train. The sequencer then loops over complete frames of all rows. When `run` is low it sits idle with every line off, so the matrix draws no readout power. The four phase lengths are counted in clock cycles and come from register inputs. They are captured at the start of each frame, so the timing can be tuned between frames. With unit lengths a row takes five cycles, which at 125 MHz or more gives a row rate above 20 MHz. Level shifting and the analog sampling are handled outside this block.

Top module: `pix_row_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, all gate and clear lines, both strobes and `frame_done` are low and `row_idx` is 0.
- R2: At most one gate line is high in any cycle. While a row is being read, only the line of that row is high, and `row_idx` gives its number.
- R3: Each row lasts S+2P+C+Q cycles, in this order: S cycles of gate settle, P cycles of the first sample window, C cycles of clear, Q cycles of post-clear settle and P cycles of the second sample window. Rows are read in ascending order 0, 1, 2, and so on.
- R4: A clear line is high only for the selected row and only during its C clear cycles, which lie between the two strobes. It is never high in a cycle with a strobe.
- R5: When idle, every line is off. If `run` is sampled high while idle, row 0 starts its settle phase in the next cycle.
- R6: `frame_done` is high for exactly one cycle, the last cycle of the final row. If `run` is high in that cycle, row 0 starts in the next cycle. Otherwise the block goes idle with all lines off.
- R7: Lowering `run` in the middle of a frame does not cut the frame short. All rows complete first.
- R8: A length input of 0 acts as a length of 1.
- R9: The length inputs are captured when a frame starts. Changing them during a frame has no effect until the next frame starts.
- R10: `sample_a` and `sample_b` each pulse for one cycle, in the first cycle of their sample window. No strobe occurs at any other time, and `row_idx` shows the row being sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| run | input | 1 | Train active; keeps the sequencer looping over frames |
| len_settle | input | LEN_W | Gate settle length S, in cycles |
| len_sample | input | LEN_W | Sample window length P, in cycles |
| len_clear | input | LEN_W | Clear pulse width C, in cycles |
| len_post | input | LEN_W | Post-clear settle length Q, in cycles |
| gate_on | output | ROWS | Gate line of each row; bit i drives row i |
| clear_on | output | ROWS | Clear line of each row; bit i drives row i |
| sample_a | output | 1 | Signal-plus-pedestal sample strobe |
| sample_b | output | 1 | Pedestal sample strobe |
| row_idx | output | clog2(ROWS) | Number of the row being read |
| frame_done | output | 1 | One-cycle pulse in the last cycle of a frame |

## Verification
With a sample window of one cycle, the pedestal strobe of the final row falls in the same cycle as `frame_done`. That cycle is also the one in which `run` decides between wrapping to row 0 and going idle, and in which new lengths are taken. The scoreboard provokes this with frames that use P = 1, and with length changes and `run` drops placed inside the preceding frame. It then requires `sample_b` and `frame_done` in that same cycle. It also requires the first row of the next frame, or the dark idle state, in the cycle after, timed with the lengths that applied to each frame.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_SAMPA  = 3'd2,
    PH_CLEAR  = 3'd3,
    PH_POST   = 3'd4,
    PH_SAMPB  = 3'd5
  } phase_e;

endpackage

// File: rtl/rowseq_timer.sv
module rowseq_timer #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  output logic             first,
  output logic             last
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;

  always_comb begin
    first = en && (cnt_q == '0);
    last  = en && (cnt_q == (len - ONE));
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // the phase length is never 0, so the count stays below it
  assert_cnt_below_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < len));

endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int LEN_W = 6,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] len_settle_i,
  input  logic [LEN_W-1:0] len_sample_i,
  input  logic [LEN_W-1:0] len_clear_i,
  input  logic [LEN_W-1:0] len_post_i,
  input  logic             tmr_first,
  input  logic             tmr_last,
  output logic             tmr_en,
  output logic [LEN_W-1:0] tmr_len,
  output phase_e           phase,
  output logic [ROW_W-1:0] row,
  output logic             sample_a,
  output logic             sample_b,
  output logic             frame_done
);

  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);

  function automatic logic [LEN_W-1:0] at_least_one(input logic [LEN_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  phase_e           state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;
  logic [LEN_W-1:0] ls_q, lp_q, lc_q, lq_q;
  logic             cap_en;
  logic             frame_end;

  // next-state logic
  always_comb begin
    frame_end = (state_q == PH_SAMPB) && tmr_last && (row_q == LAST_ROW);
    cap_en    = run && ((state_q == PH_IDLE) || frame_end);
    state_d   = state_q;
    row_d     = row_q;
    row_en    = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (run) begin
          state_d = PH_SETTLE;
          row_d   = '0;
          row_en  = 1'b1;
        end
      end
      PH_SETTLE: if (tmr_last) state_d = PH_SAMPA;
      PH_SAMPA:  if (tmr_last) state_d = PH_CLEAR;
      PH_CLEAR:  if (tmr_last) state_d = PH_POST;
      PH_POST:   if (tmr_last) state_d = PH_SAMPB;
      PH_SAMPB: begin
        if (tmr_last) begin
          row_en = 1'b1;
          if (row_q != LAST_ROW) begin
            state_d = PH_SETTLE;
            row_d   = row_q + ROW_ONE;
          end else begin
            state_d = run ? PH_SETTLE : PH_IDLE;
            row_d   = '0;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // phase length select
  always_comb begin
    tmr_en = (state_q != PH_IDLE);
    unique case (state_q)
      PH_SETTLE: tmr_len = ls_q;
      PH_SAMPA:  tmr_len = lp_q;
      PH_CLEAR:  tmr_len = lc_q;
      PH_POST:   tmr_len = lq_q;
      PH_SAMPB:  tmr_len = lp_q;
      default:   tmr_len = ONE;
    endcase
  end

  // state and row registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_d;
    end
  end

  // shadow lengths, loaded only at a frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q <= ONE;
      lp_q <= ONE;
      lc_q <= ONE;
      lq_q <= ONE;
    end else if (cap_en) begin
      ls_q <= at_least_one(len_settle_i);
      lp_q <= at_least_one(len_sample_i);
      lc_q <= at_least_one(len_clear_i);
      lq_q <= at_least_one(len_post_i);
    end
  end

  assign phase      = state_q;
  assign row        = row_q;
  assign sample_a   = (state_q == PH_SAMPA) && tmr_first;
  assign sample_b   = (state_q == PH_SAMPB) && tmr_first;
  assign frame_done = frame_end;

  assert_sample_a_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_a |-> ($past(state_q) == PH_SETTLE));

  assert_sample_b_after_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_b |-> ($past(state_q) == PH_POST));

  assert_strobes_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_a && sample_b));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_a || sample_b) |=> !(sample_a || sample_b));

  assert_row_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE && $past(state_q) != PH_IDLE) |->
      (row_q == $past(row_q) || row_q == ($past(row_q) + ROW_ONE) || row_q == '0));

endmodule

// File: rtl/rowseq_lines.sv
module rowseq_lines
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [ROW_W-1:0] row,
  output logic [ROWS-1:0]  gate_on,
  output logic [ROWS-1:0]  clear_on
);

  logic sel_any;
  logic clr_any;

  assign sel_any = (phase != PH_IDLE);
  assign clr_any = (phase == PH_CLEAR);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic hit;
    assign hit         = (row == ROW_W'(i));
    assign gate_on[i]  = sel_any && hit;
    assign clear_on[i] = clr_any && hit;
  end

  assert_one_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_on));

  assert_clear_under_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_on & ~gate_on) == '0);

endmodule

// File: rtl/pix_row_sequencer.sv
module pix_row_sequencer
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int LEN_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [LEN_W-1:0]        len_settle,
  input  logic [LEN_W-1:0]        len_sample,
  input  logic [LEN_W-1:0]        len_clear,
  input  logic [LEN_W-1:0]        len_post,
  output logic [ROWS-1:0]         gate_on,
  output logic [ROWS-1:0]         clear_on,
  output logic                    sample_a,
  output logic                    sample_b,
  output logic [$clog2(ROWS)-1:0] row_idx,
  output logic                    frame_done
);

  localparam int ROW_W = $clog2(ROWS);

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rs_q[1];

  logic             tmr_en, tmr_first, tmr_last;
  logic [LEN_W-1:0] tmr_len;
  phase_e           phase;
  logic [ROW_W-1:0] row;

  rowseq_timer #(.LEN_W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (tmr_en),
    .len   (tmr_len),
    .first (tmr_first),
    .last  (tmr_last)
  );

  rowseq_ctrl #(.ROWS(ROWS), .LEN_W(LEN_W), .ROW_W(ROW_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .run          (run),
    .len_settle_i (len_settle),
    .len_sample_i (len_sample),
    .len_clear_i  (len_clear),
    .len_post_i   (len_post),
    .tmr_first    (tmr_first),
    .tmr_last     (tmr_last),
    .tmr_en       (tmr_en),
    .tmr_len      (tmr_len),
    .phase        (phase),
    .row          (row),
    .sample_a     (sample_a),
    .sample_b     (sample_b),
    .frame_done   (frame_done)
  );

  rowseq_lines #(.ROWS(ROWS), .ROW_W(ROW_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .phase    (phase),
    .row      (row),
    .gate_on  (gate_on),
    .clear_on (clear_on)
  );

  assign row_idx = row;

  assert_no_clear_at_strobe_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_a || sample_b) |-> (clear_on == '0));

  assert_done_then_dark_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_done && !run) |=> (gate_on == '0 && clear_on == '0));

  assert_done_then_wrap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_done && run) |=> (gate_on[0] && row_idx == '0));

  assert_done_last_row_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_done |-> gate_on[ROWS-1]);

endmodule

// File: tb/pix_row_sequencer_test.sv
module pix_row_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 64;
  localparam int LEN_W = 6;

  localparam int EV_ROW  = 0;
  localparam int EV_SA   = 1;
  localparam int EV_CLR  = 2;
  localparam int EV_POST = 3;
  localparam int EV_SB   = 4;
  localparam int EV_FD   = 5;
  localparam int EV_IDLE = 6;

  typedef struct {
    int kind;
    int row;
    int cyc;
  } ev_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             run;
  logic [LEN_W-1:0] len_settle, len_sample, len_clear, len_post;
  logic [ROWS-1:0]  gate_on, clear_on;
  logic             sample_a, sample_b, frame_done;
  logic [5:0]       row_idx;

  int  cyc = 0;
  int  compared = 0;
  int  mismatched = 0;
  bit  mon_on = 1'b0;
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_row_sequencer #(.ROWS(ROWS), .LEN_W(LEN_W)) uut (
    .clk (clk), .rst_n (rst_n), .run (run),
    .len_settle (len_settle), .len_sample (len_sample),
    .len_clear (len_clear), .len_post (len_post),
    .gate_on (gate_on), .clear_on (clear_on),
    .sample_a (sample_a), .sample_b (sample_b),
    .row_idx (row_idx), .frame_done (frame_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int eff(input int v);  // R8: 0 acts as 1
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push(input int kind, input int row, input int c);
    ev_t e;
    e.kind = kind; e.row = row; e.cyc = c;
    q.push_back(e);
  endtask

  // driver side: expected events of one frame starting at cycle t0
  task automatic push_frame(input int t0, input int s, input int p, input int c,
                            input int qq, output int tnext);
    int per;
    per = s + 2*p + c + qq;
    for (int r = 0; r < ROWS; r++) begin
      int b;
      b = t0 + r*per;
      push(EV_ROW,  r, b);
      push(EV_SA,   r, b + s);
      push(EV_CLR,  r, b + s + p);
      push(EV_POST, r, b + s + p + c);
      push(EV_SB,   r, b + s + p + c + qq);
    end
    push(EV_FD, ROWS-1, t0 + ROWS*per - 1);
    tnext = t0 + ROWS*per;
  endtask

  task automatic start_run(input int s, input int p, input int c, input int qq,
                           output int t0);
    @(negedge clk);
    len_settle = LEN_W'(s); len_sample = LEN_W'(p);
    len_clear  = LEN_W'(c); len_post   = LEN_W'(qq);
    run = 1'b1;
    t0 = cyc + 1;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor side: compare outputs against the queue each cycle
  always @(negedge clk) begin
    if (mon_on) begin
      bit had_sa, had_sb, had_fd;
      had_sa = 0; had_sb = 0; had_fd = 0;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        ev_t e;
        logic [63:0] oh;
        e = q.pop_front();
        oh = 64'(1) << e.row;
        if (e.cyc < cyc) begin
          check(0, "R3", "stale event", 64'(e.kind), 64'(e.cyc));
        end else begin
          case (e.kind)
            EV_ROW: begin
              check(gate_on == oh, "R2", "gate at row start", gate_on, oh);
              check(row_idx == 6'(e.row), "R3", "row order", 64'(row_idx), 64'(e.row));
              check(clear_on == '0, "R4", "clear at row start", clear_on, 0);
            end
            EV_SA: begin
              had_sa = 1;
              check(sample_a, "R10", "sample_a strobe", 64'(sample_a), 1);
              check(row_idx == 6'(e.row), "R10", "sample_a row", 64'(row_idx), 64'(e.row));
              check(clear_on == '0, "R4", "clear at sample_a", clear_on, 0);
            end
            EV_CLR: begin
              check(clear_on == oh, "R4", "clear line", clear_on, oh);
              check(gate_on == oh, "R2", "gate during clear", gate_on, oh);
            end
            EV_POST: begin
              check(clear_on == '0, "R4", "clear after width", clear_on, 0);
              check(gate_on == oh, "R2", "gate after clear", gate_on, oh);
            end
            EV_SB: begin
              had_sb = 1;
              check(sample_b, "R10", "sample_b strobe", 64'(sample_b), 1);
              check(row_idx == 6'(e.row), "R10", "sample_b row", 64'(row_idx), 64'(e.row));
              check(clear_on == '0, "R4", "clear at sample_b", clear_on, 0);
            end
            EV_FD: begin
              had_fd = 1;
              check(frame_done, "R6", "frame_done pulse", 64'(frame_done), 1);
              check(row_idx == 6'(ROWS-1), "R6", "frame_done row", 64'(row_idx), 64'(ROWS-1));
            end
            default: begin
              check(gate_on == '0 && clear_on == '0, "R5", "idle lines dark",
                    gate_on | clear_on, 0);
            end
          endcase
        end
      end
      if (sample_a && !had_sa) check(0, "R10", "unexpected sample_a", 1, 0);
      if (sample_b && !had_sb) check(0, "R10", "unexpected sample_b", 1, 0);
      if (frame_done && !had_fd) check(0, "R6", "unexpected frame_done", 1, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run did not end", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int t0, t1, t2;
    rst_n = 1'b0; run = 1'b0;
    len_settle = '0; len_sample = '0; len_clear = '0; len_post = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gate_on == '0 && clear_on == '0, "R1", "lines in reset", gate_on | clear_on, 0);
    check(!sample_a && !sample_b && !frame_done, "R1", "strobes in reset",
          {sample_a, sample_b, frame_done}, 0);
    check(row_idx == '0, "R1", "row in reset", 64'(row_idx), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(gate_on == '0 && clear_on == '0 && !frame_done, "R1", "idle after reset",
          gate_on | clear_on, 0);
    mon_on = 1'b1;

    // unit lengths; run dropped mid-frame (R7), frame still completes; P=1 puts
    // the last sample_b and frame_done in the same cycle (R6)
    start_run(1, 1, 1, 1, t0);
    push_frame(t0, 1, 1, 1, 1, t1);
    push(EV_IDLE, 0, t1);
    push(EV_IDLE, 0, t1 + 1);
    wait_cyc(t0 + 100);
    run = 1'b0;  // R7
    wait_cyc(t1 + 4);

    // longer phases, lengths changed inside frame 1 (R9), wrap to frame 2
    start_run(3, 2, 4, 1, t0);
    push_frame(t0, 3, 2, 4, 1, t1);
    wait_cyc(t0 + 50);
    len_settle = 6'd1; len_sample = 6'd1; len_clear = 6'd1; len_post = 6'd1;  // R9
    push_frame(t1, 1, 1, 1, 1, t2);
    wait_cyc(t1 + 30);
    run = 1'b0;
    push(EV_IDLE, 0, t2);
    wait_cyc(t2 + 4);

    // zero lengths act as one (R8)
    start_run(0, 1, 2, 0, t0);
    push_frame(t0, eff(0), 1, 2, eff(0), t1);
    push(EV_IDLE, 0, t1);
    wait_cyc(t0 + 10);
    run = 1'b0;
    wait_cyc(t1 + 4);

    if (q.size() != 0) check(0, "R3", "events left unmatched", 64'(q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule